// File: doc/BRIEF.md
# Prescaled Periodic Interval Timer

This block raises a periodic interrupt. Software programs it through a single register-write port: an 8-bit scale value, a 16-bit period value and a 16-bit count value, plus a control word whose bit 0 starts and stops the timer. A prescaler divides the clock so that the count moves once every 1 to 256 cycles, as set by the scale value. When the count runs out, the timer pulses its interrupt and reloads the count from the period value in the same step. Counting carries on at the next tick with no lost cycle. Every register can be read back through a combinational read port.

A two-state machine governs counting. In STOPPED the count and the prescaler hold their values. The START transition, a control write with bit 0 set while in STOPPED, enters RUNNING and clears the prescaler. The HALT transition, a control write with bit 0 clear while in RUNNING, returns to STOPPED. Any other control write leaves the state as it is.

Top module: `interval_timer`

## Requirements
- R1: After a synchronous active-low reset, the timer is in STOPPED, the scale, period and count registers are 0, and `irq` is 0.
- R2: The register addresses are 0 for control (bit 0 = enable), 1 for scale (the low 8 bits of the write data), 2 for period and 3 for count. `rd_data` shows the addressed register in the same cycle, with unused bits read as 0. The control register reads 1 in RUNNING and 0 in STOPPED.
- R3: In RUNNING with a scale value of N, a count tick occurs once every N+1 clock cycles.
- R4: On START the prescaler is cleared, so the first tick after START comes N+1 cycles later, whatever partial prescale was held while stopped.
- R5: On a tick, a count of 2 or more decrements by 1. A count of 1 or 0 is reloaded from the period register instead, and `irq` is raised. From START with count C, the first interrupt follows C*(N+1) cycles later.
- R6: After a reload, the next interrupt follows exactly P*(N+1) cycles later for a period P of 1 or more, with no idle tick.
- R7: `irq` is high for one cycle, namely the cycle in which the count first reads the reloaded period value, whenever P*(N+1) is greater than 1.
- R8: A write to the count register takes priority over a tick in the same cycle. The written value is loaded and no interrupt is raised.
- R9: In STOPPED the count and the prescaler hold their values and `irq` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 16 | Read data for `rd_addr` |
| irq | output | 1 | Single-cycle interrupt pulse on reload |

## Verification
The bench measures the number of cycles from START to the first interrupt and between interrupts for several scale, period and count settings, including the largest scale of 255. A design that counted the zero state as an extra tick, or that divided by N instead of N+1, would give intervals that are off by one tick or by one prescale step. A directed test stops the timer partway through a prescale step and then restarts it. A prescaler that is not cleared on START would fire early. Other tests hold a count write across a pending reload and freeze a running timer. A design that let the tick win over the write would pulse `irq`, and one that kept counting while stopped would change the count.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic {
        TMR_STOPPED = 1'b0,
        TMR_RUNNING = 1'b1
    } tmr_state_e;

    localparam int ADDR_W = 2;
    localparam logic [ADDR_W-1:0] ADDR_CTRL   = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_SCALE  = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_PERIOD = 2'd2;
    localparam logic [ADDR_W-1:0] ADDR_COUNT  = 2'd3;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int SCL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clear,
    input  logic [SCL_W-1:0] scale,
    output logic             tick
);
    logic [SCL_W-1:0] pre_q;
    logic             expire;

    // >= keeps the divider live if scale is lowered mid-step
    assign expire = (pre_q >= scale);
    assign tick   = run && expire;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (clear) begin
            pre_q <= '0;
        end else if (run) begin
            if (expire) pre_q <= '0;
            else        pre_q <= pre_q + 1'b1;
        end
    end

    p_tick_restarts_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (pre_q == '0));
    p_clear_zeroes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (pre_q == '0));
    p_hold_stopped_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clear) |=> $stable(pre_q));
endmodule

// File: rtl/tmr_downcount.sv
module tmr_downcount #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] count,
    output logic             irq
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] count_q;
    logic             irq_q;
    logic             expire;

    assign expire = tick && !load && (count_q <= ONE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            irq_q   <= 1'b0;
        end else begin
            irq_q <= expire;
            if (load)        count_q <= load_val;
            else if (expire) count_q <= period;
            else if (tick)   count_q <= count_q - ONE;
        end
    end

    assign count = count_q;
    assign irq   = irq_q;

    p_write_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (!irq_q && count_q == $past(load_val)));
    p_irq_with_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> (count_q == $past(period)));
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> ($stable(count_q) && !irq_q));
endmodule

// File: rtl/interval_timer.sv
module interval_timer
    import tmr_pkg::*;
#(
    parameter int SCL_W = 8,
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    output logic              irq
);
    localparam int PAD_W = CNT_W - SCL_W;

    tmr_state_e       state_q, state_d;
    logic [SCL_W-1:0] scale_q;
    logic [CNT_W-1:0] period_q;
    logic [CNT_W-1:0] count;
    logic             ctrl_wr, count_wr;
    logic             run, start;
    logic             tick;

    assign ctrl_wr  = wr_en && (wr_addr == ADDR_CTRL);
    assign count_wr = wr_en && (wr_addr == ADDR_COUNT);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TMR_STOPPED;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        run     = 1'b0;
        start   = 1'b0;
        unique case (state_q)
            TMR_STOPPED: begin
                if (ctrl_wr && wr_data[0]) begin
                    state_d = TMR_RUNNING;   // START
                    start   = 1'b1;
                end
            end
            TMR_RUNNING: begin
                run = 1'b1;
                if (ctrl_wr && !wr_data[0]) state_d = TMR_STOPPED; // HALT
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scale_q  <= '0;
            period_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_SCALE)  scale_q  <= wr_data[SCL_W-1:0];
            if (wr_addr == ADDR_PERIOD) period_q <= wr_data;
        end
    end

    tmr_prescaler #(.SCL_W(SCL_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .clear (start),
        .scale (scale_q),
        .tick  (tick)
    );

    tmr_downcount #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load     (count_wr),
        .load_val (wr_data),
        .period   (period_q),
        .count    (count),
        .irq      (irq)
    );

    always_comb begin
        unique case (rd_addr)
            ADDR_CTRL:   rd_data = {{(CNT_W-1){1'b0}}, (state_q == TMR_RUNNING)};
            ADDR_SCALE:  rd_data = {{PAD_W{1'b0}}, scale_q};
            ADDR_PERIOD: rd_data = period_q;
            ADDR_COUNT:  rd_data = count;
        endcase
    end

    p_irq_needs_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(state_q == TMR_RUNNING));
    p_start_enters_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TMR_STOPPED && ctrl_wr && wr_data[0]) |=> (state_q == TMR_RUNNING));
endmodule

// File: tb/sim_interval_timer.sv
module sim_interval_timer;
    localparam time CLK_PERIOD = 10ns;
    localparam int  LIMIT = 2000;

    typedef struct packed {
        logic [7:0]  scale;
        logic [15:0] period;
        logic [15:0] count;
        logic [19:0] first;
        logic [19:0] next;
    } vec_t;

    localparam vec_t VEC [5] = '{
        '{8'd0,   16'd3, 16'd2, 20'd2,   20'd3},
        '{8'd2,   16'd4, 16'd1, 20'd3,   20'd12},
        '{8'd255, 16'd1, 16'd1, 20'd256, 20'd256},
        '{8'd3,   16'd5, 16'd3, 20'd12,  20'd20},
        '{8'd1,   16'd2, 16'd2, 20'd4,   20'd4}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        irq;
    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    interval_timer u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        rd_addr = a;
        #1;
        v = int'(rd_data);
    endtask

    task automatic wait_irq(output int n);
        n = 0;
        for (int i = 0; i < LIMIT; i++) begin
            @(negedge clk);
            n++;
            if (irq) break;
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_run();
    end

    initial begin
        int v, n;
        repeat (3) @(negedge clk);
        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            check("R1 reset reg", v, 0);
        end
        check("R1 reset irq", int'(irq), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 readback
        wr(2'd1, 16'h01A5); rd(2'd1, v); check("R2 scale low bits", v, 16'h00A5);
        wr(2'd2, 16'hBEEF); rd(2'd2, v); check("R2 period", v, 16'hBEEF);
        wr(2'd3, 16'h1234); rd(2'd3, v); check("R2 count", v, 16'h1234);
        wr(2'd0, 16'h0002); rd(2'd0, v); check("R2 ctrl bit0 only", v, 0);

        // R3 R5 R6 R7 vector table
        for (int k = 0; k < 5; k++) begin
            wr(2'd1, 16'(VEC[k].scale));
            wr(2'd2, VEC[k].period);
            wr(2'd3, VEC[k].count);
            wr(2'd0, 16'd1);
            rd(2'd0, v); check("R2 ctrl running", v, 1);
            wait_irq(n);
            check("R5 first interval", n, int'(VEC[k].first));
            rd(2'd3, v); check("R7 count reloaded at irq", v, int'(VEC[k].period));
            wait_irq(n);
            check("R6 R3 periodic interval", n, int'(VEC[k].next));
            wr(2'd0, 16'd0);
        end

        // R4 prescaler cleared on START
        wr(2'd1, 16'd3); wr(2'd2, 16'd10); wr(2'd3, 16'd2);
        wr(2'd0, 16'd1);
        repeat (4) @(negedge clk);
        wr(2'd0, 16'd0);
        rd(2'd3, v); check("R4 count mid-run", v, 1);
        repeat (3) @(negedge clk);
        wr(2'd0, 16'd1);
        wait_irq(n);
        check("R4 full prescale after START", n, 4);
        wr(2'd0, 16'd0);

        // R9 hold while stopped
        wr(2'd1, 16'd0); wr(2'd2, 16'd100); wr(2'd3, 16'd50);
        wr(2'd0, 16'd1);
        repeat (10) @(negedge clk);
        wr(2'd0, 16'd0);
        rd(2'd3, v); check("R9 count at halt", v, 39);
        n = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (irq) n++;
        end
        rd(2'd3, v); check("R9 count held", v, 39);
        check("R9 no irq while stopped", n, 0);

        // R8 count write priority
        wr(2'd2, 16'd5); wr(2'd3, 16'd1);
        wr(2'd0, 16'd1);
        wr_en = 1'b1; wr_addr = 2'd3; wr_data = 16'd7;
        n = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (irq) n++;
        end
        wr_en = 1'b0;
        check("R8 no irq under count write", n, 0);
        rd(2'd3, v); check("R8 written count kept", v, 7);
        wait_irq(n);
        check("R8 irq after written count", n, 7);
        wr(2'd0, 16'd0);

        finish_run();
    end
endmodule